// File: doc/BRIEF.md
# Configurable PWM Timer Channel

This block is one pulse-width-modulation timer channel. A prescaler and a selectable divider turn the system clock into a count tick. A 16-bit counter runs on that tick. It counts down in edge-aligned operation, or down and then up in center-aligned operation. The counter is compared with a period value and a duty value, which together drive one output pin. Inverter, polarity and output-enable controls sit between the comparator and the pin.

The channel raises a period flag, a duty flag and a converter-trigger flag, and software clears each flag by writing 1 to it. Software reaches the channel through a single-cycle write port and a combinational read port. Period and duty values are double-buffered, so a new setting starts at a cycle boundary.

Register addresses are CTRL 0, CLKCFG 1, PERIOD 2, COMPARE 3, COUNT 4 and FLAGS 5.

CTRL bits:
- bit0: run enable
- bit1: polarity inverse
- bit2: inverter
- bit3: auto-reload (0 means one-shot)
- bit4: center-aligned
- bit5: period-flag source
- bit6: trigger enable
- bit7: pin output enable

Top module: `pwm_timer_chan`

## Requirements
- R1: The counter advances once every (prescale+1)*D clocks, where prescale is CLKCFG[7:0] and D comes from CLKCFG[10:8]: 000 gives 2, 001 gives 4, 010 gives 8, 011 gives 16, and 100 or any other code gives 1. A start resets both stages, so the counter holds each value for exactly (prescale+1)*D clocks.
- R2: A start happens when CTRL is written with bit0=1 while the channel is stopped or halted. On that clock edge the counter loads PERIOD. In edge-aligned mode (CTRL bit4=0) each tick decrements the counter. A tick at 0 reloads PERIOD when auto-reload is set (CTRL bit3=1). Reading COUNT returns the live counter.
- R3: The raw output is high while counter > duty value, and it is always high when the period value is 0.
- R4: Values written to PERIOD and COMPARE are used only from the next start or the next tick at zero. The pin does not change until then.
- R5: In one-shot mode (CTRL bit3=0), the tick at zero halts the counter at 0 and no further events occur. Writing CTRL with bit0=1 restarts it from PERIOD.
- R6: A CTRL write that changes bit3 clears PERIOD and COMPARE to 0.
- R7: The period flag (FLAGS bit0) sets on the tick at which a down-counting counter is at 0. This applies in edge-aligned mode, and in center-aligned mode when CTRL bit5=0.
- R8: The duty flag (FLAGS bit1) sets on the tick at which a down-counting counter equals the duty value. In edge-aligned mode it never sets when the duty value equals the period value.
- R9: In center-aligned mode, the tick at 0 turns the counter upward (next value 1). The tick at the period value turns it downward. With CTRL bit5=1, the period flag sets at that upper turn and not at 0.
- R10: The trigger flag (FLAGS bit2) sets at the upper turn only when the channel is center-aligned and CTRL bit6=1. It never sets in edge-aligned mode.
- R11: Writing FLAGS clears each flag whose data bit is 1 and leaves the flags with 0 bits unchanged.
- R12: The pin output is (raw XOR inverter bit2) XOR polarity bit1, gated to 0 when CTRL bit7=0.
- R13: After reset, every register, counter and flag is 0 and the pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 16 | Read data, combinational |
| pwm_out | output | 1 | PWM pin |
| period_flag | output | 1 | Period flag |
| duty_flag | output | 1 | Duty flag |
| trig_flag | output | 1 | Converter-trigger flag |

## Verification
A wrong divider or prescaler state shows up within one counter period as a wrong number of high clocks on the pin. It also shows as a COUNT value that differs from the period after the expected number of clocks. A wrong direction bit or a wrong shadow value shows within a few ticks, either as a COUNT that moves the wrong way or as a flag that sets on the wrong tick. A halt state that does not hold shows as a period flag that sets again after it has been cleared.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int DSEL_W = 3;
    localparam int DIV_W  = 5;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL    = 3'd0,
        A_CLKCFG  = 3'd1,
        A_PERIOD  = 3'd2,
        A_COMPARE = 3'd3,
        A_COUNT   = 3'd4,
        A_FLAGS   = 3'd5
    } reg_addr_e;

    // bit7 .. bit0 of CTRL
    typedef struct packed {
        logic oe;
        logic trig_en;
        logic ptype;
        logic center;
        logic auto_rl;
        logic inv;
        logic pinv;
        logic en;
    } ctrl_t;

    // bit2 .. bit0 of FLAGS
    typedef struct packed {
        logic trig;
        logic duty;
        logic period;
    } evt_t;

    function automatic logic [DIV_W-1:0] div_from_sel(input logic [DSEL_W-1:0] sel);
        case (sel)
            3'b000:  return DIV_W'(2);
            3'b001:  return DIV_W'(4);
            3'b010:  return DIV_W'(8);
            3'b011:  return DIV_W'(16);
            default: return DIV_W'(1);
        endcase
    endfunction
endpackage

// File: rtl/pwm_clkdiv.sv
module pwm_clkdiv
    import pwm_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              run,
    input  logic [PRE_W-1:0]  presc,
    input  logic [DSEL_W-1:0] dsel,
    output logic              tick
);
    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_last;
    logic             pre_wrap;
    logic             div_wrap;

    assign div_last = div_from_sel(dsel) - DIV_W'(1);
    assign pre_wrap = (pre_cnt == presc);
    assign div_wrap = (div_cnt >= div_last);
    assign tick     = run && pre_wrap && div_wrap;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (run) begin
            if (pre_wrap) begin
                pre_cnt <= '0;
                div_cnt <= div_wrap ? '0 : div_cnt + DIV_W'(1);
            end else begin
                pre_cnt <= pre_cnt + PRE_W'(1);
            end
        end
    end
endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  evt_t              evt,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              halted,
    output ctrl_t             ctrl,
    output logic [PRE_W-1:0]  presc,
    output logic [DSEL_W-1:0] dsel,
    output logic [CNT_W-1:0]  period_reg,
    output logic [CNT_W-1:0]  cmp_reg,
    output evt_t              flags,
    output logic              start
);
    localparam int CTRL_W = $bits(ctrl_t);
    localparam int FLG_W  = $bits(evt_t);
    localparam int CLK_W  = PRE_W + DSEL_W;

    logic             wr_ctrl, wr_clk, wr_per, wr_cmp, wr_flg;
    ctrl_t            ctrl_new;
    logic             mode_flip;
    logic [FLG_W-1:0] flags_q;
    logic [FLG_W-1:0] clr_mask;
    logic             unused_wdata;

    assign unused_wdata = ^wr_data;

    assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
    assign wr_clk   = wr_en && (wr_addr == A_CLKCFG);
    assign wr_per   = wr_en && (wr_addr == A_PERIOD);
    assign wr_cmp   = wr_en && (wr_addr == A_COMPARE);
    assign wr_flg   = wr_en && (wr_addr == A_FLAGS);

    assign ctrl_new  = ctrl_t'(wr_data[CTRL_W-1:0]);
    assign mode_flip = wr_ctrl && (ctrl_new.auto_rl != ctrl.auto_rl);
    assign start     = wr_ctrl && ctrl_new.en && (!ctrl.en || halted);
    assign clr_mask  = wr_flg ? wr_data[FLG_W-1:0] : '0;
    assign flags     = evt_t'(flags_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl       <= '0;
            presc      <= '0;
            dsel       <= '0;
            period_reg <= '0;
            cmp_reg    <= '0;
            flags_q    <= '0;
        end else begin
            if (wr_ctrl) ctrl <= ctrl_new;
            if (wr_clk) begin
                presc <= wr_data[PRE_W-1:0];
                dsel  <= wr_data[CLK_W-1:PRE_W];
            end
            if (mode_flip) begin
                period_reg <= '0;
                cmp_reg    <= '0;
            end else begin
                if (wr_per) period_reg <= wr_data;
                if (wr_cmp) cmp_reg    <= wr_data;
            end
            flags_q <= (flags_q & ~clr_mask) | FLG_W'(evt);
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:    rd_data = CNT_W'(ctrl);
            A_CLKCFG:  rd_data = CNT_W'({dsel, presc});
            A_PERIOD:  rd_data = period_reg;
            A_COMPARE: rd_data = cmp_reg;
            A_COUNT:   rd_data = cnt;
            A_FLAGS:   rd_data = CNT_W'(flags_q);
            default:   rd_data = '0;
        endcase
    end

    AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && (ctrl_new.auto_rl != ctrl.auto_rl)) |=> (period_reg == '0 && cmp_reg == '0)); // R6

    AST_FLAG_W1C: assert property (@(posedge clk) disable iff (rst)
        (wr_flg && wr_data[0] && !evt.period) |=> !flags.period); // R11
endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             tick,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] period_reg,
    input  logic [CNT_W-1:0] cmp_reg,
    output logic [CNT_W-1:0] cnt,
    output logic             halted,
    output logic             running,
    output evt_t             evt,
    output logic             pwm_out
);
    logic [CNT_W-1:0] per_sh;
    logic [CNT_W-1:0] cmp_sh;
    logic             dir_up;
    logic             at_zero_dn;
    logic             at_top_up;
    logic             underflow;
    logic             top_turn;
    logic             raw;
    logic             inv_stage;
    logic             pol_stage;

    assign running    = ctrl.en && !halted;
    assign at_zero_dn = !dir_up && (cnt == '0);
    assign at_top_up  = dir_up && (cnt >= per_sh);
    assign underflow  = tick && at_zero_dn;
    assign top_turn   = tick && ctrl.center && at_top_up;

    always_comb begin
        evt.period = ctrl.center && ctrl.ptype ? top_turn : underflow;
        evt.trig   = top_turn && ctrl.trig_en;
        evt.duty   = tick && !dir_up && (cnt == cmp_sh) &&
                     (ctrl.center || (cmp_sh != per_sh));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            per_sh <= '0;
            cmp_sh <= '0;
            dir_up <= 1'b0;
            halted <= 1'b0;
        end else if (start) begin
            cnt    <= period_reg;
            per_sh <= period_reg;
            cmp_sh <= cmp_reg;
            dir_up <= 1'b0;
            halted <= 1'b0;
        end else if (tick) begin
            if (at_zero_dn) begin
                per_sh <= period_reg;
                cmp_sh <= cmp_reg;
                if (!ctrl.auto_rl) begin
                    halted <= 1'b1;
                end else if (ctrl.center) begin
                    if (period_reg != '0) begin
                        dir_up <= 1'b1;
                        cnt    <= CNT_W'(1);
                    end
                end else begin
                    cnt <= period_reg;
                end
            end else if (dir_up) begin
                if (at_top_up) begin
                    dir_up <= 1'b0;
                    cnt    <= cnt - CNT_W'(1);
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

    assign raw       = (per_sh == '0) || (cnt > cmp_sh);
    assign inv_stage = raw ^ ctrl.inv;
    assign pol_stage = inv_stage ^ ctrl.pinv;
    assign pwm_out   = ctrl.oe && pol_stage;

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && !dir_up && (cnt != '0) && !start) |=> (cnt == $past(cnt) - CNT_W'(1))); // R2

    AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (halted && !start) |=> (cnt == $past(cnt))); // R5
endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              pwm_out,
    output logic              period_flag,
    output logic              duty_flag,
    output logic              trig_flag
);
    ctrl_t             ctrl;
    evt_t              evt;
    evt_t              flags;
    logic [PRE_W-1:0]  presc;
    logic [DSEL_W-1:0] dsel;
    logic [CNT_W-1:0]  period_reg;
    logic [CNT_W-1:0]  cmp_reg;
    logic [CNT_W-1:0]  cnt;
    logic              halted;
    logic              running;
    logic              start;
    logic              tick;

    pwm_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) i_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .evt(evt), .cnt(cnt), .halted(halted),
        .ctrl(ctrl), .presc(presc), .dsel(dsel),
        .period_reg(period_reg), .cmp_reg(cmp_reg),
        .flags(flags), .start(start)
    );

    pwm_clkdiv #(.PRE_W(PRE_W)) i_clkdiv (
        .clk(clk), .rst(rst), .restart(start), .run(running),
        .presc(presc), .dsel(dsel), .tick(tick)
    );

    pwm_core #(.CNT_W(CNT_W)) i_core (
        .clk(clk), .rst(rst), .start(start), .tick(tick),
        .ctrl(ctrl), .period_reg(period_reg), .cmp_reg(cmp_reg),
        .cnt(cnt), .halted(halted), .running(running),
        .evt(evt), .pwm_out(pwm_out)
    );

    assign period_flag = flags.period;
    assign duty_flag   = flags.duty;
    assign trig_flag   = flags.trig;

    AST_TRIG_CENTER: assert property (@(posedge clk) disable iff (rst)
        $rose(trig_flag) |-> $past(ctrl.center)); // R10
endmodule

// File: tb/test_pwm_timer_chan.sv
`timescale 1ns/1ps
module test_pwm_timer_chan;
    localparam logic [2:0] A_CTRL = 3'd0, A_CLK = 3'd1, A_PER = 3'd2,
                           A_CMP = 3'd3, A_CNT = 3'd4, A_FLG = 3'd5;
    localparam logic [15:0] EN = 16'h01, PINV = 16'h02, INV = 16'h04, AUTO = 16'h08,
                            CENTER = 16'h10, PTYPE = 16'h20, TRIG = 16'h40, OE = 16'h80;

    typedef struct packed {
        logic [7:0]  presc;
        logic [2:0]  dsel;
        logic [15:0] per;
        logic [15:0] cmp;
        logic [15:0] exp_hi;
        logic [15:0] total;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'd0, 3'd4, 16'd5, 16'd2, 16'd3,  16'd6},
        '{8'd0, 3'd4, 16'd9, 16'd0, 16'd9,  16'd10},
        '{8'd0, 3'd4, 16'd6, 16'd6, 16'd0,  16'd7},
        '{8'd0, 3'd4, 16'd3, 16'd8, 16'd0,  16'd4},
        '{8'd0, 3'd4, 16'd0, 16'd0, 16'd5,  16'd5},
        '{8'd1, 3'd0, 16'd3, 16'd1, 16'd8,  16'd16},
        '{8'd0, 3'd1, 16'd2, 16'd0, 16'd8,  16'd12},
        '{8'd2, 3'd4, 16'd4, 16'd2, 16'd6,  16'd15},
        '{8'd0, 3'd3, 16'd1, 16'd0, 16'd16, 16'd32}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = A_CNT;
    logic [15:0] rd_data;
    logic        pwm_out, period_flag, duty_flag, trig_flag;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_timer_chan i_pwm_timer_chan (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out),
        .period_flag(period_flag), .duty_flag(duty_flag), .trig_flag(trig_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_addr = a;
        #0.5;
        v = int'(rd_data);
    endtask

    initial begin
        int v;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R13 reset state
        chk("R13 pin", int'(pwm_out), 0);
        chk("R13 flags", int'({trig_flag, duty_flag, period_flag}), 0);
        rd(A_CNT, v); chk("R13 count", v, 0);
        rd(A_PER, v); chk("R13 period", v, 0);

        // R1 R2 R3: edge-aligned vector table
        for (int i = 0; i < NV; i++) begin
            int hi;
            hi = 0;
            wr(A_CTRL, OE | AUTO);
            wr(A_CLK, {5'd0, VECS[i].dsel, VECS[i].presc});
            wr(A_PER, VECS[i].per);
            wr(A_CMP, VECS[i].cmp);
            wr(A_CTRL, OE | AUTO | TRIG | EN);
            for (int k = 0; k < int'(VECS[i].total); k++) begin
                hi += int'(pwm_out);
                @(negedge clk);
            end
            chk($sformatf("R1 R3 high clocks vec%0d", i), hi, int'(VECS[i].exp_hi));
            rd(A_CNT, v);
            chk($sformatf("R2 reload count vec%0d", i), v, int'(VECS[i].per));
        end
        chk("R10 no trigger in edge mode", int'(trig_flag), 0);

        // R7 R8 R11: edge flags
        wr(A_CTRL, OE | AUTO);
        wr(A_FLG, 16'h7);
        wr(A_CLK, 16'h0400);
        wr(A_PER, 16'd5);
        wr(A_CMP, 16'd2);
        wr(A_CTRL, OE | AUTO | EN);
        cyc(3);
        chk("R8 duty not yet", int'(duty_flag), 0);
        cyc(1);
        chk("R8 duty at compare", int'(duty_flag), 1);
        chk("R7 period not yet", int'(period_flag), 0);
        cyc(2);
        chk("R7 period at underflow", int'(period_flag), 1);
        rd(A_CNT, v); chk("R2 reloaded", v, 5);
        wr(A_CTRL, OE | AUTO);
        wr(A_FLG, 16'h0);
        chk("R11 zero write keeps", int'({duty_flag, period_flag}), 3);
        wr(A_FLG, 16'h2);
        chk("R11 clear duty only", int'({duty_flag, period_flag}), 1);
        wr(A_FLG, 16'h1);
        chk("R11 clear period", int'(period_flag), 0);

        // R8: compare equal to period in edge mode
        wr(A_PER, 16'd3);
        wr(A_CMP, 16'd3);
        wr(A_CTRL, OE | AUTO | EN);
        cyc(10);
        chk("R8 duty silent when cmp==per", int'(duty_flag), 0);
        chk("R7 period with cmp==per", int'(period_flag), 1);

        // R4: shadowed compare
        wr(A_CTRL, OE | AUTO);
        wr(A_FLG, 16'h7);
        wr(A_PER, 16'd7);
        wr(A_CMP, 16'd2);
        wr(A_CTRL, OE | AUTO | EN);
        cyc(1);
        wr(A_CMP, 16'd6);
        chk("R4 old compare still used", int'(pwm_out), 1);
        rd(A_CMP, v); chk("R4 compare readback", v, 6);
        cyc(6);
        begin
            int hi;
            hi = 0;
            for (int k = 0; k < 8; k++) begin
                hi += int'(pwm_out);
                @(negedge clk);
            end
            chk("R4 new compare next cycle", hi, 1);
        end

        // R6: mode change clears period and compare
        wr(A_CTRL, OE | AUTO);
        wr(A_PER, 16'd9);
        wr(A_CMP, 16'd4);
        rd(A_PER, v); chk("R6 period written", v, 9);
        wr(A_CTRL, OE);
        rd(A_PER, v); chk("R6 period cleared", v, 0);
        rd(A_CMP, v); chk("R6 compare cleared", v, 0);

        // R5: one-shot
        wr(A_PER, 16'd3);
        wr(A_CMP, 16'd0);
        wr(A_FLG, 16'h7);
        wr(A_CTRL, OE | EN);
        cyc(3);
        rd(A_CNT, v); chk("R5 reached zero", v, 0);
        chk("R5 no flag before tick at zero", int'(period_flag), 0);
        cyc(1);
        chk("R5 flag at tick at zero", int'(period_flag), 1);
        cyc(6);
        rd(A_CNT, v); chk("R5 held at zero", v, 0);
        chk("R5 pin low while halted", int'(pwm_out), 0);
        wr(A_FLG, 16'h1);
        cyc(5);
        chk("R5 no events while halted", int'(period_flag), 0);
        wr(A_CTRL, OE | EN);
        rd(A_CNT, v); chk("R5 restart loads period", v, 3);

        // R9 R10: center-aligned, flag at upper turn, trigger on
        wr(A_CTRL, OE | AUTO | CENTER | PTYPE | TRIG);
        wr(A_FLG, 16'h7);
        wr(A_PER, 16'd4);
        wr(A_CMP, 16'd1);
        wr(A_CTRL, OE | AUTO | CENTER | PTYPE | TRIG | EN);
        cyc(4);
        chk("R8 center duty while down", int'(duty_flag), 1);
        chk("R9 no period flag yet", int'(period_flag), 0);
        chk("R10 no trigger yet", int'(trig_flag), 0);
        cyc(2);
        rd(A_CNT, v); chk("R9 counting up", v, 2);
        chk("R9 underflow ignored with type 1", int'(period_flag), 0);
        cyc(3);
        chk("R9 period flag at upper turn", int'(period_flag), 1);
        chk("R10 trigger at upper turn", int'(trig_flag), 1);
        rd(A_CNT, v); chk("R9 turned down", v, 3);

        // R9 R10: center-aligned, flag at underflow, trigger off
        wr(A_CTRL, OE | AUTO | CENTER);
        wr(A_FLG, 16'h7);
        wr(A_CTRL, OE | AUTO | CENTER | EN);
        cyc(5);
        chk("R9 period flag at underflow", int'(period_flag), 1);
        rd(A_CNT, v); chk("R9 first up value", v, 1);
        wr(A_FLG, 16'h1);
        cyc(3);
        chk("R9 upper turn ignored with type 0", int'(period_flag), 0);
        chk("R10 trigger disabled", int'(trig_flag), 0);
        cyc(4);
        chk("R9 next underflow", int'(period_flag), 1);

        // R3 R12: period 0 and output stage
        wr(A_CTRL, OE | AUTO);
        wr(A_PER, 16'd0);
        wr(A_CMP, 16'd0);
        wr(A_CTRL, OE | AUTO | EN);
        chk("R3 period zero high", int'(pwm_out), 1);
        cyc(5);
        chk("R3 period zero stays high", int'(pwm_out), 1);
        wr(A_CTRL, AUTO | EN);
        chk("R12 gate off", int'(pwm_out), 0);
        wr(A_CTRL, OE | AUTO | EN | INV);
        chk("R12 inverter", int'(pwm_out), 0);
        wr(A_CTRL, OE | AUTO | EN | INV | PINV);
        chk("R12 inverter and polarity", int'(pwm_out), 1);
        wr(A_CTRL, OE | AUTO | EN | PINV);
        chk("R12 polarity", int'(pwm_out), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule